// File: doc/BRIEF.md
# Multi-Cycle 8-Bit Accumulator Core

A small processor that executes one-byte instructions from a 16-byte memory holding both program and data. It has four 8-bit general registers, a 4-bit program counter, an instruction register, a temporary result register and two condition flags. Each instruction is handled in separate clock steps. A fetch step reads the byte at the program counter and advances the counter. A decode step turns that byte into control fields. An execute step then acts on it. Arithmetic adds a write-back step that moves the staged result into register 0.

The test environment fills the memory through a preload port while reset is held. It then releases reset and watches the halted output and the debug outputs for the registers, program counter and flags. Programs end with a halt instruction, so data bytes stored after the code are never run.

Top module: `mc8_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter, all four registers and both flags clear and `halted` is low. The first instruction after reset is fetched from address 0.
- R2: An instruction byte is decoded as follows. Bits [7:6] give the class: 00 arithmetic, 01 load, 10 store, 11 control. Bits [5:4] select a register, an operation or a control kind. Bits [3:0] hold a memory address or a jump target.
- R3: Every fetch adds one to the program counter, modulo 16. Load, store, jump and halt each take three cycles: fetch, decode, execute.
- R4: Arithmetic computes R0 op R1 modulo 256 and writes the result to R0, leaving R1 to R3 unchanged. The operation is set by bits [5:4]: 00 add, 01 subtract (R0-R1), 10 multiply (low 8 bits kept), 11 bitwise AND.
- R5: The arithmetic result is staged in a temporary register during execute and reaches R0 one cycle later, so an arithmetic instruction takes four cycles.
- R6: Load (class 01) copies memory[addr] into the register selected by bits [5:4]. Store (class 10) writes that register to memory[addr].
- R7: Control kind 00 is an unconditional jump. It replaces the program counter with bits [3:0], so the next fetch comes from the target.
- R8: Control kind 01 jumps when the zero flag is set, and kind 10 jumps when the negative flag is set. After a subtraction of values that differ by less than 128, these two jumps tell apart R0<R1, R0==R1 and R0>R1.
- R9: Control kind 11 halts. `halted` rises once that instruction has executed and stays high until reset. The program counter and registers hold, and bytes after the halt are never run.
- R10: After an arithmetic instruction, the zero flag is set exactly when the 8-bit result is 0 and the negative flag equals result bit 7. No other instruction changes the flags.
- R11: With `rst` high, a cycle with `pl_we` high writes `pl_data` to address `pl_addr`. Memory contents survive a later reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pl_we | input | 1 | Preload write strobe, honoured while reset is high |
| pl_addr | input | 4 | Preload byte address |
| pl_data | input | 8 | Preload byte value |
| halted | output | 1 | High once a halt instruction has executed |
| pc_dbg | output | 4 | Current program counter |
| regs_dbg | output | 32 | Register i on bits [8i+7:8i] |
| flag_zero | output | 1 | Zero flag |
| flag_neg | output | 1 | Negative flag |

## Verification
The bench builds the core with its only configuration: 8-bit data, 4-bit addresses and four registers. At this size the operand space is small enough to sweep densely. All four operations are run against 256 operand pairs, and every R0/R1 pair from 0 to 15 goes through the three-way compare program, so both flag polarities and both taken and not-taken branches are covered. Directed programs check the step timing cycle by cycle, load/store round trips at the extreme byte values, jumps, halting before a data byte that would decode as a load, and memory that persists across reset.

// File: rtl/mc8_pkg.sv
package mc8_pkg;

    localparam int DW   = 8;
    localparam int AW   = 4;
    localparam int NREG = 4;
    localparam int RSW  = 2;

    typedef enum logic [1:0] {
        CL_ALU   = 2'b00,
        CL_LOAD  = 2'b01,
        CL_STORE = 2'b10,
        CL_CTRL  = 2'b11
    } cls_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_MUL = 2'b10,
        OP_AND = 2'b11
    } aluop_e;

    typedef enum logic [1:0] {
        CT_JMP  = 2'b00,
        CT_JZ   = 2'b01,
        CT_JN   = 2'b10,
        CT_HALT = 2'b11
    } ctl_e;

    typedef enum logic [2:0] {
        ST_FETCH  = 3'd0,
        ST_DECODE = 3'd1,
        ST_EXEC   = 3'd2,
        ST_WB     = 3'd3,
        ST_HALT   = 3'd4
    } state_e;

    typedef struct packed {
        cls_e            cls;
        logic [RSW-1:0]  sel;
        logic [AW-1:0]   addr;
    } instr_t;

    typedef struct packed {
        logic z;
        logic n;
    } flags_t;

    typedef struct packed {
        logic            is_alu;
        logic            is_load;
        logic            is_store;
        logic            take_jump;
        logic            is_halt;
        aluop_e          op;
        logic [RSW-1:0]  sel;
        logic [AW-1:0]   addr;
    } ctrl_t;

    function automatic ctrl_t decode(instr_t ir, flags_t fl);
        ctrl_t c;
        c           = '0;
        c.sel       = ir.sel;
        c.addr      = ir.addr;
        c.op        = aluop_e'(ir.sel);
        c.is_alu    = (ir.cls == CL_ALU);
        c.is_load   = (ir.cls == CL_LOAD);
        c.is_store  = (ir.cls == CL_STORE);
        if (ir.cls == CL_CTRL) begin
            case (ctl_e'(ir.sel))
                CT_JMP:  c.take_jump = 1'b1;
                CT_JZ:   c.take_jump = fl.z;
                CT_JN:   c.take_jump = fl.n;
                default: c.is_halt   = 1'b1;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/mc8_mem.sv
module mc8_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/mc8_regs.sv
module mc8_regs #(
    parameter int DATA_W = 8,
    parameter int NREG   = 4,
    localparam int SW    = $clog2(NREG)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [SW-1:0]          waddr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [SW-1:0]          raddr,
    output logic [DATA_W-1:0]      rdata,
    output logic [NREG*DATA_W-1:0] flat
);
    logic [DATA_W-1:0] q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                               q[i] <= '0;
            else if (we && (waddr == SW'(i)))      q[i] <= wdata;
        end
        assign flat[i*DATA_W +: DATA_W] = q[i];
    end

    assign rdata = q[raddr];
endmodule

// File: rtl/mc8_alu.sv
module mc8_alu #(
    parameter int DATA_W = 8
) (
    input  mc8_pkg::aluop_e    op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  y,
    output mc8_pkg::flags_t    fl
);
    import mc8_pkg::*;

    logic [2*DATA_W-1:0] prod;

    assign prod = a * b;

    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[DATA_W-1:0];
            default: y = a & b;
        endcase
        fl.z = (y == '0);
        fl.n = y[DATA_W-1];
    end
endmodule

// File: rtl/mc8_seq.sv
module mc8_seq
    import mc8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DW-1:0]     mem_rdata,
    input  logic [DW-1:0]     reg_rdata,
    input  logic [DW-1:0]     alu_y,
    input  flags_t            alu_fl,
    output logic [AW-1:0]     mem_raddr,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [DW-1:0]     mem_wdata,
    output logic              reg_we,
    output logic [RSW-1:0]    reg_waddr,
    output logic [DW-1:0]     reg_wdata,
    output logic [RSW-1:0]    reg_raddr,
    output aluop_e            alu_op,
    output logic [AW-1:0]     pc,
    output flags_t            flags,
    output logic              halted
);
    localparam logic [AW-1:0] PC_INC = AW'(1);

    state_e          state_q;
    logic [AW-1:0]   pc_q;
    instr_t          ir_q;
    ctrl_t           dec_q;
    logic [DW-1:0]   tmp_q;
    flags_t          flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
            ir_q    <= '0;
            dec_q   <= '0;
            tmp_q   <= '0;
            flags_q <= '0;
        end else begin
            case (state_q)
                ST_FETCH: begin
                    ir_q    <= instr_t'(mem_rdata);
                    pc_q    <= pc_q + PC_INC;
                    state_q <= ST_DECODE;
                end
                ST_DECODE: begin
                    dec_q   <= decode(ir_q, flags_q);
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (dec_q.is_alu) begin
                        tmp_q   <= alu_y;
                        flags_q <= alu_fl;
                        state_q <= ST_WB;
                    end else if (dec_q.is_halt) begin
                        state_q <= ST_HALT;
                    end else begin
                        if (dec_q.take_jump) pc_q <= dec_q.addr;
                        state_q <= ST_FETCH;
                    end
                end
                ST_WB:   state_q <= ST_FETCH;
                default: state_q <= ST_HALT;
            endcase
        end
    end

    always_comb begin
        mem_raddr = (state_q == ST_FETCH) ? pc_q : dec_q.addr;
        mem_we    = (state_q == ST_EXEC) && dec_q.is_store;
        mem_waddr = dec_q.addr;
        mem_wdata = reg_rdata;
        reg_raddr = dec_q.sel;
        reg_we    = (state_q == ST_WB) || ((state_q == ST_EXEC) && dec_q.is_load);
        reg_waddr = (state_q == ST_WB) ? '0 : dec_q.sel;
        reg_wdata = (state_q == ST_WB) ? tmp_q : mem_rdata;
        alu_op    = dec_q.op;
    end

    assign pc     = pc_q;
    assign flags  = flags_q;
    assign halted = (state_q == ST_HALT);

    // R3
    pc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FETCH) |=> (pc_q == $past(pc_q) + PC_INC));

    // R7
    jump_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && dec_q.take_jump) |=> (pc_q == $past(dec_q.addr)));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_EXEC || !dec_q.is_alu) |=> $stable(flags_q));

    // R9
    halt_stick_chk: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(pc_q)));

    // R5
    wb_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EXEC && dec_q.is_alu) |=> (state_q == ST_WB && reg_wdata == tmp_q));
endmodule

// File: rtl/mc8_core.sv
module mc8_core
    import mc8_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pl_we,
    input  logic [AW-1:0]        pl_addr,
    input  logic [DW-1:0]        pl_data,
    output logic                 halted,
    output logic [AW-1:0]        pc_dbg,
    output logic [NREG*DW-1:0]   regs_dbg,
    output logic                 flag_zero,
    output logic                 flag_neg
);
    logic [DW-1:0]  mem_rdata, reg_rdata, alu_y, core_wdata, reg_wdata, m_wdata;
    logic [AW-1:0]  mem_raddr, core_waddr, m_waddr;
    logic           core_we, m_we, reg_we;
    logic [RSW-1:0] reg_waddr, reg_raddr;
    flags_t         alu_fl, flags;
    aluop_e         alu_op;

    assign m_we    = rst ? pl_we   : core_we;
    assign m_waddr = rst ? pl_addr : core_waddr;
    assign m_wdata = rst ? pl_data : core_wdata;

    mc8_mem #(.DATA_W(DW), .ADDR_W(AW)) u_mem (
        .clk(clk), .we(m_we), .waddr(m_waddr), .wdata(m_wdata),
        .raddr(mem_raddr), .rdata(mem_rdata)
    );

    mc8_regs #(.DATA_W(DW), .NREG(NREG)) u_regs (
        .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
        .raddr(reg_raddr), .rdata(reg_rdata), .flat(regs_dbg)
    );

    mc8_alu #(.DATA_W(DW)) u_alu (
        .op(alu_op), .a(regs_dbg[0 +: DW]), .b(regs_dbg[DW +: DW]),
        .y(alu_y), .fl(alu_fl)
    );

    mc8_seq u_seq (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .reg_rdata(reg_rdata),
        .alu_y(alu_y), .alu_fl(alu_fl), .mem_raddr(mem_raddr), .mem_we(core_we),
        .mem_waddr(core_waddr), .mem_wdata(core_wdata), .reg_we(reg_we),
        .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_raddr(reg_raddr),
        .alu_op(alu_op), .pc(pc_dbg), .flags(flags), .halted(halted)
    );

    assign flag_zero = flags.z;
    assign flag_neg  = flags.n;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pc_dbg == '0 && regs_dbg == '0 && !halted));
endmodule

// File: tb/mc8_core_tb.sv
module mc8_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pl_we = 1'b0;
    logic [3:0]  pl_addr = '0;
    logic [7:0]  pl_data = '0;
    logic        halted;
    logic [3:0]  pc_dbg;
    logic [31:0] regs_dbg;
    logic        flag_zero, flag_neg;

    logic [7:0]  img [16];
    int          n_chk = 0;
    int          n_bad = 0;
    int          cyc;

    always #5 clk = ~clk;

    mc8_core dut_i (
        .clk(clk), .rst(rst), .pl_we(pl_we), .pl_addr(pl_addr), .pl_data(pl_data),
        .halted(halted), .pc_dbg(pc_dbg), .regs_dbg(regs_dbg),
        .flag_zero(flag_zero), .flag_neg(flag_neg)
    );

    function automatic logic [7:0] rg(int i);
        return regs_dbg[i*8 +: 8];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_img();
        for (int i = 0; i < 16; i++) img[i] = 8'h00;
    endtask

    // hold reset, optionally preload img, release reset
    task automatic start(bit load);
        @(negedge clk);
        rst = 1'b1;
        if (load) begin
            for (int a = 0; a < 16; a++) begin
                pl_we = 1'b1; pl_addr = 4'(a); pl_data = img[a];
                @(negedge clk);
            end
        end else begin
            repeat (3) @(negedge clk);
        end
        pl_we = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
    endtask

    task automatic step(int n);
        repeat (n) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic run_to_halt(string req);
        while (!halted && cyc < 300) step(1);
        if (!halted) chk({req, " hung"}, 0, 1);
    endtask

    function automatic logic [7:0] alu_ref(int op, int a, int b);
        case (op)
            0: return 8'((a + b) & 255);
            1: return 8'((a - b) & 255);
            2: return 8'((a * b) & 255);
            default: return 8'(a & b);
        endcase
    endfunction

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state and first fetch from address 0
        clear_img();
        img[0] = 8'h7F; img[1] = 8'hF0; img[15] = 8'hC6;
        start(1'b1);
        chk("R1 pc", 32'(pc_dbg), 0);
        chk("R1 regs", regs_dbg, 0);
        chk("R1 flags", {flag_zero, flag_neg}, 0);
        chk("R1 halted", 32'(halted), 0);
        run_to_halt("R1");
        chk("R1 first instr at 0", 32'(rg(3)), 32'hC6);

        // R3 R5 cycle timing: LOAD, LOAD, ADD, HALT
        clear_img();
        img[0] = 8'h4E; img[1] = 8'h5F; img[2] = 8'h00; img[3] = 8'hF0;
        img[14] = 8'd5; img[15] = 8'd7;
        start(1'b1);
        step(1);  chk("R3 pc after fetch", 32'(pc_dbg), 1);
        step(1);  chk("R3 R0 before exec", 32'(rg(0)), 0);
        step(1);  chk("R3 load at cycle 3", 32'(rg(0)), 5);
        step(1);  chk("R3 second fetch", 32'(pc_dbg), 2);
        step(5);  chk("R5 R0 held at cycle 9", 32'(rg(0)), 5);
        step(1);  chk("R5 R0 written at cycle 10", 32'(rg(0)), 12);
        step(2);  chk("R9 not halted at 12", 32'(halted), 0);
        step(1);  chk("R9 halted at 13", 32'(halted), 1);

        // R4 R10 R2 arithmetic sweep
        for (int op = 0; op < 4; op++) begin
            for (int i = 0; i < 16; i++) begin
                for (int j = 0; j < 16; j++) begin
                    int a, b;
                    logic [7:0] y;
                    a = (i == 0) ? 0 : ((i * 53 + 7) & 255);
                    b = (i == j) ? a : ((j * 29 + 3) & 255);
                    clear_img();
                    img[0] = 8'h4E; img[1] = 8'h5F; img[2] = 8'(op << 4); img[3] = 8'hF0;
                    img[14] = 8'(a); img[15] = 8'(b);
                    start(1'b1);
                    run_to_halt("R4");
                    y = alu_ref(op, a, b);
                    chk("R4 result", 32'(rg(0)), 32'(y));
                    chk("R4 R1 kept", 32'(rg(1)), 32'(b));
                    chk("R10 zero", 32'(flag_zero), 32'(y == 0));
                    chk("R10 neg", 32'(flag_neg), 32'(y[7]));
                end
            end
        end

        // R8 three-way compare
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                clear_img();
                img[0] = 8'h4E; img[1] = 8'h5F; img[2] = 8'h10; img[3] = 8'hD7;
                img[4] = 8'hE9; img[5] = 8'h6D; img[6] = 8'hF0; img[7] = 8'h6C;
                img[8] = 8'hF0; img[9] = 8'h6B; img[10] = 8'hF0;
                img[11] = 8'h3C; img[12] = 8'h5A; img[13] = 8'hA5;
                img[14] = 8'(a); img[15] = 8'(b);
                start(1'b1);
                run_to_halt("R8");
                chk("R8 compare", 32'(rg(2)),
                    (a == b) ? 32'h5A : ((a < b) ? 32'h3C : 32'hA5));
            end
        end

        // R6 store/load round trips
        for (int k = 0; k < 4; k++) begin
            logic [7:0] d;
            d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h81 : 8'h7E;
            clear_img();
            img[0] = 8'h6C; img[1] = 8'hAD; img[2] = 8'h7D; img[3] = 8'hBE;
            img[4] = 8'h5E; img[5] = 8'hF0; img[12] = d;
            img[13] = ~d; img[14] = ~d;
            start(1'b1);
            run_to_halt("R6");
            chk("R6 load R2", 32'(rg(2)), 32'(d));
            chk("R6 store then load R3", 32'(rg(3)), 32'(d));
            chk("R6 second store R1", 32'(rg(1)), 32'(d));
        end

        // R7 unconditional jump skips instructions
        clear_img();
        img[0] = 8'hC3; img[1] = 8'h4F; img[2] = 8'hF0; img[3] = 8'h5F;
        img[4] = 8'hF0; img[15] = 8'h99;
        start(1'b1);
        run_to_halt("R7");
        chk("R7 skipped load", 32'(rg(0)), 0);
        chk("R7 target load", 32'(rg(1)), 32'h99);
        chk("R7 pc", 32'(pc_dbg), 5);

        // R9 halt is permanent, data after it not run
        clear_img();
        img[0] = 8'h4F; img[1] = 8'hF0; img[2] = 8'h5F; img[15] = 8'h42;
        start(1'b1);
        run_to_halt("R9");
        step(30);
        chk("R9 still halted", 32'(halted), 1);
        chk("R9 pc held", 32'(pc_dbg), 2);
        chk("R9 data byte not run", 32'(rg(1)), 0);
        chk("R9 R0", 32'(rg(0)), 32'h42);

        // R10 flags untouched by load/store
        clear_img();
        img[0] = 8'h4E; img[1] = 8'h5F; img[2] = 8'h10; img[3] = 8'h4D;
        img[4] = 8'h8C; img[5] = 8'hF0; img[13] = 8'h80;
        img[14] = 8'h33; img[15] = 8'h33;
        start(1'b1);
        run_to_halt("R10");
        chk("R10 zero kept", 32'(flag_zero), 1);
        chk("R10 neg kept", 32'(flag_neg), 0);
        chk("R10 R0 loaded", 32'(rg(0)), 32'h80);

        // R11 memory survives reset without preload
        start(1'b0);
        chk("R11 reset regs", regs_dbg, 0);
        run_to_halt("R11");
        chk("R11 rerun R0", 32'(rg(0)), 32'h80);
        chk("R11 rerun zero", 32'(flag_zero), 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule